// File: doc/BRIEF.md
# Reset Sequencer with Boot-Mode and Tri-State Capture

This block generates the internal reset of a small controller-class chip from two sources: an active-low external reset pin and a synchronous reset request raised by an on-chip watchdog. Either source drives the internal reset high. After the active source goes away, the internal reset is held for a fixed number of extra cycles, so that downstream flops see a clean, synchronous deassertion.

The block also captures two strap inputs: a boot-mode select bus and an active-low tri-state request. It captures them only when the external pin reset ends. The tri-state request must be seen low for a full window of consecutive synchronized cycles just before that release. When it is, the block clears a global output-enable so that every pad driver can be turned off for board-level debug.

A watchdog reset never touches the captured values. A status bit records whether the pin or the watchdog started the most recent reset, and the pin wins when both are active. The asynchronous power-on input puts the block in its default state: outputs enabled, boot mode zero, and internal reset asserted.

Top module: `rstmode_ctrl`

## Requirements
- R1: Two synchronizer stages sit on the reset pin. When `ext_rst_n` is driven low while `int_rst` is low, `int_rst` is still low after the second rising edge and is high after the third. It then stays high for as long as the pin is held low.
- R2: When `wdt_req` is high at a rising edge, `int_rst` is high after that edge.
- R3: Once the active source goes away, `int_rst` stays high for HOLD_CYCLES (4) extra edges. After a watchdog request is dropped, it goes low on the 5th rising edge. After the pin is released, it goes low on the 7th rising edge, because synchronization adds two edges.
- R4: When the pin is released, tri-state mode is latched if `tri_req_n` was low on each of the final TRI_WINDOW (10) cycles of the low pin period. `out_en` is then 0.
- R5: If `tri_req_n` was low for fewer than TRI_WINDOW consecutive final cycles, `out_en` is 1 after the release. This includes the case where a single high cycle breaks the run.
- R6: `boot_mode` takes the value of `boot_sel` sampled when the synchronized pin release is detected. Later changes of `boot_sel` have no effect.
- R7: A watchdog reset leaves `boot_mode` and `out_en` unchanged, whatever `boot_sel` and `tri_req_n` do during it.
- R8: While the pin and the watchdog are active together, `rst_src` is 0 (pin). The pin release then samples the mode inputs, even if the watchdog request is still high.
- R9: While and directly after `por_n` is low, `int_rst` is 1, `out_en` is 1, `boot_mode` is 0 and `rst_src` is 0.
- R10: A watchdog request that rises while the pin is inactive sets `rst_src` to 1 (watchdog).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, synchronous, active high |
| boot_sel | input | BOOT_W | Boot-mode strap input |
| tri_req_n | input | 1 | Tri-state request strap, active low, asynchronous |
| int_rst | output | 1 | Internal synchronous reset, active high |
| boot_mode | output | BOOT_W | Latched boot mode |
| out_en | output | 1 | Global pad output-enable, low in tri-state mode |
| rst_src | output | 1 | Source of last reset: 0 pin, 1 watchdog |

## Verification
The pin reset and the watchdog reset can overlap, and the block must decide which one owns the source flag and the mode capture. The bench drives both sources low and high in the same cycle, keeps the watchdog asserted past the pin release, and then feeds `tri_req_n` and `boot_sel` values that a watchdog-owned reset would have to ignore. It then checks that `rst_src` reads the pin during the overlap and that the straps present at the pin release are the ones latched. It also checks that a later watchdog-only reset leaves both latches unchanged.

// File: rtl/rstmode_pkg.sv
package rstmode_pkg;
    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_WDT = 1'b1
    } rst_src_e;
endpackage

// File: rtl/rstmode_sync.sv
// Multi-stage synchronizer bank with a programmable reset value per bit.
module rstmode_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rstmode_trcnt.sv
// Saturating count of consecutive low tri-state request samples during pin reset.
module rstmode_trcnt #(
    parameter int LIMIT = 10,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          in_rst,
    input  logic          req_low,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!in_rst || !req_low) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rstmode_ctrl.sv
// Reset sequencer: merges pin and watchdog resets, captures straps on pin release.
module rstmode_ctrl
    import rstmode_pkg::*;
#(
    parameter int BOOT_W      = 2,
    parameter int TRI_WINDOW  = 10,
    parameter int HOLD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wdt_req,
    input  logic [BOOT_W-1:0] boot_sel,
    input  logic              tri_req_n,
    output logic              int_rst,
    output logic [BOOT_W-1:0] boot_mode,
    output logic              out_en,
    output logic              rst_src
);
    localparam int CW = $clog2(TRI_WINDOW + 1);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] WIN  = CW'(TRI_WINDOW);
    localparam logic [HW-1:0] HOLD = HW'(HOLD_CYCLES);

    typedef struct packed {
        logic              ext_prev;
        logic              wdt_prev;
        logic              rst;
        logic [HW-1:0]     hold;
        logic              tri_mode;
        logic [BOOT_W-1:0] boot;
        rst_src_e          src;
    } state_t;

    localparam state_t ST_RESET = '{
        ext_prev: 1'b1, wdt_prev: 1'b0, rst: 1'b1, hold: HOLD,
        tri_mode: 1'b0, boot: '0, src: SRC_PIN
    };

    logic          ext_s, tri_s;
    logic [CW-1:0] low_cnt;
    logic          rel, active;
    state_t        st_d, st_q;

    rstmode_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk   (clk),
        .arst_n(por_n),
        .d     ({ext_rst_n, tri_req_n}),
        .q     ({ext_s, tri_s})
    );

    rstmode_trcnt #(
        .LIMIT(TRI_WINDOW),
        .CW   (CW)
    ) u_trcnt (
        .clk    (clk),
        .arst_n (por_n),
        .in_rst (~ext_s),
        .req_low(~tri_s),
        .cnt    (low_cnt)
    );

    always_comb begin
        st_d          = st_q;
        rel           = ext_s & ~st_q.ext_prev;
        active        = ~ext_s | wdt_req;
        st_d.ext_prev = ext_s;
        st_d.wdt_prev = wdt_req;

        // reset stretch
        if (active) begin
            st_d.hold = HOLD;
            st_d.rst  = 1'b1;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
            st_d.rst  = 1'b1;
        end else begin
            st_d.rst  = 1'b0;
        end

        // source flag: pin dominates, watchdog only on its own rising edge
        if (!ext_s) begin
            st_d.src = SRC_PIN;
        end else if (wdt_req && !st_q.wdt_prev) begin
            st_d.src = SRC_WDT;
        end

        // strap capture only on synchronized pin release
        if (rel) begin
            st_d.tri_mode = (low_cnt == WIN);
            st_d.boot     = boot_sel;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_rst   = st_q.rst;
    assign boot_mode = st_q.boot;
    assign out_en    = ~st_q.tri_mode;
    assign rst_src   = st_q.src;
endmodule

// File: rtl/rstmode_ctrl_chk.sv
module rstmode_ctrl_chk #(
    parameter int BOOT_W     = 2,
    parameter int TRI_WINDOW = 10,
    parameter int CW         = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              ext_s,
    input logic              ext_prev,
    input logic              wdt_req,
    input logic [CW-1:0]     low_cnt,
    input logic              int_rst,
    input logic [BOOT_W-1:0] boot_mode,
    input logic              out_en,
    input logic              rst_src
);
    AST_RST_ON_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_s || wdt_req) |=> int_rst);                                  // R2
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        $fell(int_rst) |-> $past(ext_s && !wdt_req));                      // R3
    AST_TRI_ENTER: assert property (@(posedge clk) disable iff (!por_n)
        (ext_s && !ext_prev && low_cnt == CW'(TRI_WINDOW)) |=> !out_en);   // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        low_cnt <= CW'(TRI_WINDOW));                                       // R5
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !(ext_s && !ext_prev) |=> ($stable(boot_mode) && $stable(out_en))); // R7
    AST_PIN_WINS: assert property (@(posedge clk) disable iff (!por_n)
        !ext_s |=> (rst_src == 1'b0));                                     // R8
endmodule

bind rstmode_ctrl rstmode_ctrl_chk #(
    .BOOT_W    (BOOT_W),
    .TRI_WINDOW(TRI_WINDOW),
    .CW        (CW)
) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .ext_s    (ext_s),
    .ext_prev (st_q.ext_prev),
    .wdt_req  (wdt_req),
    .low_cnt  (low_cnt),
    .int_rst  (int_rst),
    .boot_mode(boot_mode),
    .out_en   (out_en),
    .rst_src  (rst_src)
);

// File: tb/rstmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module rstmode_ctrl_tb_top;
    localparam int WIN  = 10;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       por_n, ext_rst_n, wdt_req, tri_req_n;
    logic [1:0] boot_sel;
    logic       int_rst, out_en, rst_src;
    logic [1:0] boot_mode;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    rstmode_ctrl #(.BOOT_W(2), .TRI_WINDOW(WIN), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_req(wdt_req),
        .boot_sel(boot_sel), .tri_req_n(tri_req_n), .int_rst(int_rst),
        .boot_mode(boot_mode), .out_en(out_en), .rst_src(rst_src)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // count negedges after a source goes away until int_rst reads low
    task automatic count_hold(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (int_rst && n < 40);
    endtask

    // pin reset of len cycles; tri_req_n low on the last tail cycles, except glitch index
    task automatic pin_reset(input int len, input int tail, input int glitch, input logic [1:0] bs);
        int n;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ext_rst_n = 1'b0;
            boot_sel  = bs;
            tri_req_n = !((i >= len - tail) && (i != glitch));
        end
        @(negedge clk);
        ext_rst_n = 1'b1;
        tri_req_n = 1'b1;
        repeat (4) @(negedge clk);
        boot_sel = ~bs;
        count_hold(n);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            fails++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        por_n = 1'b0; ext_rst_n = 1'b1; wdt_req = 1'b0; tri_req_n = 1'b1; boot_sel = 2'd3;
        repeat (3) @(negedge clk);
        // R9 defaults
        expect_eq("R9 int_rst", int_rst, 1);
        expect_eq("R9 out_en", out_en, 1);
        expect_eq("R9 boot_mode", boot_mode, 0);
        expect_eq("R9 rst_src", rst_src, 0);
        por_n = 1'b1;
        @(negedge clk);
        expect_eq("R9 out_en after por", out_en, 1);
        expect_eq("R9 boot_mode after por", boot_mode, 0);
        repeat (10) @(negedge clk);
        expect_eq("R3 quiet after por", int_rst, 0);

        // R1 assertion latency, R3 pin stretch
        ext_rst_n = 1'b0; boot_sel = 2'd1;
        @(negedge clk); expect_eq("R1 edge1", int_rst, 0);
        @(negedge clk); expect_eq("R1 edge2", int_rst, 0);
        @(negedge clk); expect_eq("R1 edge3", int_rst, 1);
        repeat (12) @(negedge clk);
        expect_eq("R1 held", int_rst, 1);
        ext_rst_n = 1'b1;
        count_hold(n);
        expect_eq("R3 pin stretch", n, HOLD + 3);
        expect_eq("R6 boot after first release", boot_mode, 1);
        expect_eq("R10 pin source", rst_src, 0);

        // R4 R5 R6 sweep of trailing-low lengths
        for (int t = 0; t <= 12; t++) begin
            pin_reset(14, t, -1, 2'(t % 4));
            expect_eq(t >= WIN ? "R4 tri enter" : "R5 tri reject", out_en, (t >= WIN) ? 0 : 1);
            expect_eq("R6 boot latch", boot_mode, t % 4);
        end

        // R5 single high cycle breaks the run: trailing 5 lows
        pin_reset(20, 20, 14, 2'd0);
        expect_eq("R5 glitch", out_en, 1);

        // enter tri-state with boot 2, then watchdog reset
        pin_reset(16, 12, -1, 2'd2);
        expect_eq("R4 tri set", out_en, 0);
        @(negedge clk);
        wdt_req = 1'b1; tri_req_n = 1'b1; boot_sel = 2'd1;
        @(negedge clk);
        expect_eq("R2 wdt assert", int_rst, 1);
        expect_eq("R10 wdt source", rst_src, 1);
        repeat (14) @(negedge clk);
        wdt_req = 1'b0;
        count_hold(n);
        expect_eq("R3 wdt stretch", n, HOLD + 1);
        expect_eq("R7 out_en kept", out_en, 0);
        expect_eq("R7 boot kept", boot_mode, 2);

        // watchdog with tri low for a long run, starting from normal mode
        pin_reset(14, 0, -1, 2'd1);
        expect_eq("R5 back to normal", out_en, 1);
        @(negedge clk);
        wdt_req = 1'b1; tri_req_n = 1'b0; boot_sel = 2'd3;
        repeat (15) @(negedge clk);
        wdt_req = 1'b0; tri_req_n = 1'b1;
        count_hold(n);
        expect_eq("R7 tri ignored", out_en, 1);
        expect_eq("R7 boot ignored", boot_mode, 1);
        expect_eq("R10 source wdt", rst_src, 1);

        // R8 overlap: both sources, watchdog outlives pin
        @(negedge clk);
        ext_rst_n = 1'b0; wdt_req = 1'b1; tri_req_n = 1'b0; boot_sel = 2'd3;
        repeat (4) @(negedge clk);
        expect_eq("R8 pin wins", rst_src, 0);
        repeat (12) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        tri_req_n = 1'b1; boot_sel = 2'd0;
        repeat (3) @(negedge clk);
        expect_eq("R8 rst during wdt", int_rst, 1);
        wdt_req = 1'b0;
        count_hold(n);
        expect_eq("R8 source kept pin", rst_src, 0);
        expect_eq("R8 tri sampled", out_en, 0);
        expect_eq("R8 boot sampled", boot_mode, 3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule